// File: doc/BRIEF.md
# Fuse Packet-to-Logical Map Decoder

This block turns a compressed physical fuse image into a flat logical byte map. When `start` is pulsed it first erases the whole logical map by writing 0xFF to every logical address. It then walks the physical image one byte at a time through a read port with a fixed one-cycle latency. The walk begins just past a reserved secure-control region at the bottom of the image. The image is a chain of packets. Each packet is a two-byte header that names a block and lists which of its four 16-bit words follow, and then the words that are present.

Each word that is present is copied, two bytes at a time, to its place in the logical map through a valid/ready write port. The walk ends normally on an erased header byte or when the offset reaches the usable limit. It ends with an error when a word would run past the usable physical range or past the logical map. A one-cycle `done` pulse reports the end of the walk, and `err` is qualified by it. Sizes are parameters: PHYS_SIZE bytes of physical image, SEC_SIZE bytes reserved at each end, and LOG_SIZE logical bytes, where LOG_SIZE is even.

Top module: `fuse_map_decoder`

## Requirements
- R1: After `start`, the first LOG_SIZE accepted writes carry data 0xFF to logical addresses 0, 1, ..., LOG_SIZE-1 in ascending order.
- R2: Parsing begins at physical offset SEC_SIZE. No byte below SEC_SIZE and no byte above PHYS_SIZE-SEC_SIZE is ever read.
- R3: A header whose first byte or second byte equals 0xFF ends the walk normally (`err`=0). Bytes that follow it have no effect.
- R4: The block index is {hdr1[3:0], hdr2[7:4]}, so hdr1[7:4] is ignored. Word i of block b lands at logical bytes 8*b+2*i (first physical byte) and 8*b+2*i+1 (second physical byte). A later packet overwrites an earlier one.
- R5: hdr2[3:0] is an active-low word mask: bit i set means word i is absent. Present words are taken in ascending i, each from the next two physical bytes. A header whose mask is 0xF carries no words and is followed directly by the next header.
- R6: If a present word starting at offset p has p+2 > PHYS_SIZE-SEC_SIZE, the walk stops with `err`=1. The word is not written, but earlier words stay written.
- R7: If a present word's second logical byte 8*b+2*i+1 would be ≥ LOG_SIZE, the walk stops with `err`=1 and the word is not written.
- R8: When the header offset reaches PHYS_SIZE-SEC_SIZE, the walk ends normally with `err`=0 and no further read is made.
- R9: `done` is high for exactly one cycle per walk. `err` is high only together with `done`. Neither a read nor a write is requested while `done` is high.
- R10: The write port obeys valid/ready. Once `wr_valid` is high it stays high, with `wr_addr` and `wr_data` unchanged, until `wr_ready` accepts the write. No read is requested while a write is pending.
- R11: After reset `done`, `err`, `wr_valid` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk; ignored while one is running |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Bounds error, valid with done |
| rd_en | output | 1 | Physical byte read request |
| rd_addr | output | $clog2(PHYS_SIZE) | Physical byte offset |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| wr_valid | output | 1 | Logical write offered |
| wr_ready | input | 1 | Logical write accepted when high with wr_valid |
| wr_addr | output | $clog2(LOG_SIZE) | Logical byte address |
| wr_data | output | 8 | Logical byte value |

## Verification
The assertions assume that the read memory returns data exactly one cycle after `rd_en` and that `start` is not raised during a walk. The bench's memory model always answers on the next edge, and the bench pulses `start` only once the previous `done` has been seen. `wr_ready` is driven either steadily high or randomly low on about a quarter of cycles, so the hold rule is exercised under back-pressure. Directed images reach each end condition at its exact boundary, and random images of packed packets mix absent words, out-of-range blocks and overwrites.

// File: rtl/fuse_dec_pkg.sv
package fuse_dec_pkg;
  localparam int BLK_W = 8;
  localparam int WORDS = 4;
  localparam int IDX_W = $clog2(WORDS);
  localparam logic [7:0] ERASED = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLEAR, ST_SCAN, ST_HDR1, ST_HDR2, ST_WSEL,
    ST_BYTE0, ST_BYTE1, ST_WR0, ST_WR1, ST_FIN
  } dec_state_t;

  typedef struct packed {
    logic [BLK_W-1:0] blk;
    logic [WORDS-1:0] absent;
    logic             stop;
  } hdr_info_t;
endpackage

// File: rtl/fuse_hdr_decode.sv
module fuse_hdr_decode
  import fuse_dec_pkg::*;
(
  input  logic [7:0] first_byte,
  input  logic [7:0] second_byte,
  output hdr_info_t  info
);
  always_comb begin
    info.stop   = (first_byte == ERASED) || (second_byte == ERASED);
    info.blk    = {first_byte[3:0], second_byte[7:4]};
    info.absent = second_byte[WORDS-1:0];
  end
endmodule

// File: rtl/fuse_word_pick.sv
module fuse_word_pick
  import fuse_dec_pkg::*;
(
  input  logic [WORDS-1:0] absent,
  input  logic [IDX_W:0]   from_idx,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest present word at or above from_idx
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (!absent[i] && (32'(i) >= 32'(from_idx))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/fuse_bound_check.sv
module fuse_bound_check
  import fuse_dec_pkg::*;
#(
  parameter int PA_W     = 6,
  parameter int LIMIT    = 60,
  parameter int LOG_SIZE = 64,
  localparam int LC_W    = BLK_W + IDX_W + 1
) (
  input  logic [PA_W:0]      phy,
  input  logic [BLK_W-1:0]   blk,
  input  logic [IDX_W-1:0]   idx,
  output logic [LC_W-1:0]    log_addr,
  output logic               bad
);
  logic phys_over, log_over;
  always_comb begin
    log_addr  = {blk, idx, 1'b0};
    phys_over = (32'(phy) + 32'd2) > 32'(LIMIT);
    log_over  = (32'(log_addr) + 32'd1) >= 32'(LOG_SIZE);
    bad       = phys_over || log_over;
  end
endmodule

// File: rtl/fuse_map_decoder.sv
module fuse_map_decoder
  import fuse_dec_pkg::*;
#(
  parameter int PHYS_SIZE = 64,
  parameter int LOG_SIZE  = 64,
  parameter int SEC_SIZE  = 4,
  localparam int PA_W     = $clog2(PHYS_SIZE),
  localparam int LA_W     = $clog2(LOG_SIZE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            done,
  output logic            err,
  output logic            rd_en,
  output logic [PA_W-1:0] rd_addr,
  input  logic [7:0]      rd_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [LA_W-1:0] wr_addr,
  output logic [7:0]      wr_data
);
  localparam int LIMIT = PHYS_SIZE - SEC_SIZE;
  localparam int LC_W  = BLK_W + IDX_W + 1;
  localparam logic [PA_W:0]   LIM_V  = (PA_W+1)'(LIMIT);
  localparam logic [PA_W:0]   SEC_V  = (PA_W+1)'(SEC_SIZE);
  localparam logic [LA_W-1:0] LAST_L = LA_W'(LOG_SIZE - 1);

  dec_state_t       state;
  logic [PA_W:0]    phy;
  logic [LA_W-1:0]  clr;
  logic [7:0]       hdr1_q, lo_q, hi_q;
  logic [BLK_W-1:0] blk_q;
  logic [WORDS-1:0] absent_q;
  logic [IDX_W:0]   widx;
  logic [IDX_W-1:0] cur_q;
  logic [LA_W-1:0]  log_q;
  logic             err_q;

  hdr_info_t        info;
  logic             found, bad;
  logic [IDX_W-1:0] pidx;
  logic [LC_W-1:0]  log_addr;

  fuse_hdr_decode u_hdr (
    .first_byte (hdr1_q),
    .second_byte(rd_data),
    .info       (info)
  );

  fuse_word_pick u_pick (
    .absent  (absent_q),
    .from_idx(widx),
    .found   (found),
    .idx     (pidx)
  );

  fuse_bound_check #(.PA_W(PA_W), .LIMIT(LIMIT), .LOG_SIZE(LOG_SIZE)) u_bound (
    .phy     (phy),
    .blk     (blk_q),
    .idx     (pidx),
    .log_addr(log_addr),
    .bad     (bad)
  );

  always_comb begin
    rd_en    = 1'b0;
    rd_addr  = phy[PA_W-1:0];
    wr_valid = 1'b0;
    wr_addr  = log_q;
    wr_data  = lo_q;
    unique case (state)
      ST_SCAN:  rd_en = (phy < LIM_V);
      ST_HDR1:  begin rd_en = 1'b1; rd_addr = phy[PA_W-1:0] + 1'b1; end
      ST_WSEL:  rd_en = found && !bad;
      ST_BYTE0: begin rd_en = 1'b1; rd_addr = phy[PA_W-1:0] + 1'b1; end
      ST_CLEAR: begin wr_valid = 1'b1; wr_addr = clr; wr_data = ERASED; end
      ST_WR0:   wr_valid = 1'b1;
      ST_WR1:   begin wr_valid = 1'b1; wr_addr = log_q | LA_W'(1); wr_data = hi_q; end
      default:  ;
    endcase
  end

  assign done = (state == ST_FIN);
  assign err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phy      <= '0;
      clr      <= '0;
      hdr1_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      blk_q    <= '0;
      absent_q <= '0;
      widx     <= '0;
      cur_q    <= '0;
      log_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          clr   <= '0;
          state <= ST_CLEAR;
        end
        ST_CLEAR: if (wr_ready) begin
          if (clr == LAST_L) begin
            phy   <= SEC_V;
            state <= ST_SCAN;
          end else begin
            clr <= clr + 1'b1;
          end
        end
        ST_SCAN: begin
          if (phy >= LIM_V) begin
            err_q <= 1'b0;
            state <= ST_FIN;
          end else begin
            state <= ST_HDR1;
          end
        end
        ST_HDR1: begin
          hdr1_q <= rd_data;
          state  <= ST_HDR2;
        end
        ST_HDR2: begin
          if (info.stop) begin
            err_q <= 1'b0;
            state <= ST_FIN;
          end else begin
            blk_q    <= info.blk;
            absent_q <= info.absent;
            phy      <= phy + 2'd2;
            widx     <= '0;
            state    <= ST_WSEL;
          end
        end
        ST_WSEL: begin
          if (!found) begin
            state <= ST_SCAN;
          end else if (bad) begin
            err_q <= 1'b1;
            state <= ST_FIN;
          end else begin
            log_q <= log_addr[LA_W-1:0];
            cur_q <= pidx;
            state <= ST_BYTE0;
          end
        end
        ST_BYTE0: begin
          lo_q  <= rd_data;
          state <= ST_BYTE1;
        end
        ST_BYTE1: begin
          hi_q  <= rd_data;
          state <= ST_WR0;
        end
        ST_WR0: if (wr_ready) state <= ST_WR1;
        ST_WR1: if (wr_ready) begin
          phy   <= phy + 2'd2;
          widx  <= {1'b0, cur_q} + 1'b1;
          state <= ST_WSEL;
        end
        ST_FIN: begin
          err_q <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuse_map_decoder_chk.sv
module fuse_map_decoder_chk #(
  parameter int PHYS_SIZE = 64,
  parameter int LOG_SIZE  = 64,
  parameter int SEC_SIZE  = 4,
  localparam int PA_W     = $clog2(PHYS_SIZE),
  localparam int LA_W     = $clog2(LOG_SIZE)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            done,
  input logic            err,
  input logic            rd_en,
  input logic [PA_W-1:0] rd_addr,
  input logic [7:0]      rd_data,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [LA_W-1:0] wr_addr,
  input logic [7:0]      wr_data
);
  localparam int LIMIT = PHYS_SIZE - SEC_SIZE;

  p_rd_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(rd_addr) >= 32'(SEC_SIZE)) && (32'(rd_addr) <= 32'(LIMIT)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_quiet_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_valid && !rd_en));

  p_hold_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_no_read_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_en);
endmodule

bind fuse_map_decoder fuse_map_decoder_chk #(
  .PHYS_SIZE(PHYS_SIZE), .LOG_SIZE(LOG_SIZE), .SEC_SIZE(SEC_SIZE)
) i_chk (.*);

// File: tb/test_fuse_map_decoder.sv
`timescale 1ns/1ps
module test_fuse_map_decoder;
  localparam int PHYS = 64;
  localparam int LOGS = 64;
  localparam int SEC  = 4;
  localparam int LIM  = PHYS - SEC;
  localparam int PA_W = $clog2(PHYS);
  localparam int LA_W = $clog2(LOGS);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            done, err, rd_en, wr_valid;
  logic            wr_ready = 1'b0;
  logic [PA_W-1:0] rd_addr;
  logic [7:0]      rd_data = 8'h00;
  logic [LA_W-1:0] wr_addr;
  logic [7:0]      wr_data;

  always #2 clk = ~clk;

  fuse_map_decoder #(.PHYS_SIZE(PHYS), .LOG_SIZE(LOGS), .SEC_SIZE(SEC)) i_fuse_map_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic [7:0] img [PHYS];
  logic [7:0] got [LOGS];
  logic [7:0] expm [LOGS];
  int  exp_a[$];
  int  exp_d[$];
  int  wr_seen;
  bit  exp_err;
  bit  running = 1'b0;
  bit  stall = 1'b0;
  int  done_cnt;
  bit  done_err;
  int  errors = 0;
  int  checks = 0;

  // one-cycle-latency physical memory
  always @(posedge clk) if (rd_en) rd_data <= img[rd_addr];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // behavioural model of the walk
  task automatic build_expect();
    int p;
    exp_a.delete(); exp_d.delete();
    for (int a = 0; a < LOGS; a++) begin exp_a.push_back(a); exp_d.push_back(8'hFF); end
    p = SEC; exp_err = 1'b0;
    while (p < LIM) begin
      int h1, h2, blk, msk;
      bit stop_now;
      h1 = img[p]; h2 = img[p+1];
      if (h1 == 8'hFF || h2 == 8'hFF) break;
      blk = ((h1 & 15) * 16) + (h2 / 16);
      msk = h2 & 15;
      p += 2;
      stop_now = 1'b0;
      for (int i = 0; i < 4; i++) begin
        int la;
        if (((msk >> i) & 1) == 1) continue;
        la = blk * 8 + i * 2;
        if (p + 2 > LIM || la + 1 >= LOGS) begin exp_err = 1'b1; stop_now = 1'b1; break; end
        exp_a.push_back(la);     exp_d.push_back(img[p]);
        exp_a.push_back(la + 1); exp_d.push_back(img[p+1]);
        p += 2;
      end
      if (stop_now) break;
    end
    for (int a = 0; a < LOGS; a++) expm[a] = 8'h00;
    foreach (exp_a[k]) expm[exp_a[k]] = exp_d[k][7:0];
  endtask

  // ready driver and per-clock write comparison
  initial begin
    forever begin
      bit rdy;
      @(negedge clk);
      rdy = stall ? (($urandom % 4) != 0) : 1'b1;
      wr_ready = rdy;
      if (rst_n && running) begin
        if (wr_valid && rdy) begin
          if (exp_a.size() == 0) begin
            chk(1'b0, "R3", "unexpected write addr", int'(wr_addr), -1);
          end else begin
            chk(int'(wr_addr) == exp_a[0] && int'(wr_data) == exp_d[0],
                (wr_seen < LOGS) ? "R1" : "R4/R5",
                "write addr/data", int'({wr_addr, wr_data}), (exp_a[0] * 256) + exp_d[0]);
            void'(exp_a.pop_front()); void'(exp_d.pop_front());
          end
          got[wr_addr] = wr_data;
          wr_seen++;
        end
        if (done) begin done_cnt++; done_err = err; end
      end
    end
  end

  task automatic run(string req, bit use_stall);
    int waited;
    int mism;
    build_expect();
    for (int a = 0; a < LOGS; a++) got[a] = 8'h00;
    wr_seen = 0; done_cnt = 0; done_err = 1'b0; stall = use_stall;
    @(negedge clk); running = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waited = 0;
    while (done_cnt == 0 && waited < 5000) begin @(negedge clk); waited++; end
    chk(done_cnt == 1, "R9", "done seen", done_cnt, 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
    chk(done == 1'b0 && err == 1'b0, "R9", "done/err low after pulse", {done, err}, 0);
    chk(done_err == exp_err, req, "err at done", done_err, exp_err);
    chk(exp_a.size() == 0, req, "writes missing", exp_a.size(), 0);
    mism = 0;
    for (int a = 0; a < LOGS; a++) if (got[a] !== expm[a]) mism++;
    chk(mism == 0, req, "logical map mismatches", mism, 0);
    running = 1'b0;
  endtask

  task automatic blank();
    for (int a = 0; a < PHYS; a++) img[a] = 8'hFF;
  endtask

  // writes one packet at p with word data derived from seed, returns next offset
  task automatic pkt(inout int p, input int h1, input int h2, input int seed);
    img[p] = h1[7:0]; img[p+1] = h2[7:0]; p += 2;
    for (int i = 0; i < 4; i++) begin
      if (((h2 >> i) & 1) == 0) begin
        img[p] = 8'((seed * 7 + i * 2) & 8'h7F); img[p+1] = 8'((seed * 13 + i * 2 + 1) & 8'h7F);
        p += 2;
      end
    end
  endtask

  initial begin
    int p;
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p;
    blank();
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && err == 1'b0 && wr_valid == 1'b0 && rd_en == 1'b0,
        "R11", "outputs in reset", {done, err, wr_valid, rd_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && wr_valid == 1'b0 && rd_en == 1'b0, "R11", "idle after reset",
        {done, wr_valid, rd_en}, 0);

    // R1/R3: blank image
    blank(); run("R3", 1'b0);
    // R1 with back-pressure
    blank(); run("R1", 1'b1);

    // R2/R4: reserved bytes look like packets but are skipped
    blank();
    for (int a = 0; a < SEC; a++) img[a] = 8'h00;
    p = SEC; pkt(p, 8'h00, 8'h10, 1);
    run("R2", 1'b1);

    // R5: masks, empty-word header, single high word
    blank(); p = SEC;
    pkt(p, 8'h00, 8'h2A, 2); pkt(p, 8'h00, 8'h5F, 3); pkt(p, 8'h00, 8'h77, 4);
    run("R5", 1'b0);

    // R3: hdr2 erased ends walk; following packet has no effect
    blank(); p = SEC;
    pkt(p, 8'h00, 8'h30, 5); img[p] = 8'h00; img[p+1] = 8'hFF; p += 2;
    pkt(p, 8'h00, 8'h40, 6);
    run("R3", 1'b1);

    // R4: hdr1 upper nibble ignored, overwrite by later packet
    blank(); p = SEC;
    pkt(p, 8'hE0, 8'h3C, 7); pkt(p, 8'h50, 8'h3E, 8);
    run("R4", 1'b0);

    // R7: block 8 runs past the logical map
    blank(); p = SEC;
    pkt(p, 8'h00, 8'h60, 9); pkt(p, 8'h00, 8'h80, 10);
    run("R7", 1'b1);

    // R7: word 3 of block 7 is the last legal one; block 7 all words fine
    blank(); p = SEC;
    pkt(p, 8'h00, 8'h70, 11);
    run("R7", 1'b0);

    // R6: third word of last packet crosses the physical limit
    blank(); p = SEC;
    for (int k = 0; k < 5; k++) pkt(p, 8'h00, (k << 4), 20 + k);
    pkt(p, 8'h00, 8'h50, 30);
    for (int a = LIM; a < PHYS; a++) img[a] = 8'h00;
    run("R6", 1'b1);

    // R8: packets end exactly at the limit
    blank(); p = SEC;
    for (int k = 0; k < 5; k++) pkt(p, 8'h00, (k << 4), 40 + k);
    pkt(p, 8'h00, 8'h6C, 50);
    for (int a = LIM; a < PHYS; a++) img[a] = 8'h00;
    chk(p == LIM, "R8", "image layout", p, LIM);
    run("R8", 1'b0);

    // random packed images
    for (int t = 0; t < 8; t++) begin
      blank(); p = SEC;
      while (p + 10 <= LIM) begin
        int b;
        b = $urandom % 10;
        pkt(p, (($urandom % 16) << 4), (b << 4) | ($urandom % 16), $urandom % 100);
      end
      run("R4/R5/R6/R7", t[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule